// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control and address core of a single DMA channel. Software programs a bank of sixteen 32-bit words. It sets the source and destination addresses, a per-side step, a beat width for each side, and three nested byte lengths: fragment, block and transaction. The block then issues one beat per cycle. Each beat is a pair of 36-bit source and destination addresses. The block counts the bytes moved against the three lengths and signals each boundary to the interrupt unit as a one-cycle pulse.

Transfers move only when a request has been granted. A request comes from a software write or from the hardware request pin, and one request covers one unit of work: a fragment, a block or the whole transaction, depending on the request mode. Software can stop the channel with a pause request and wait for the acknowledge bit before it touches state. A channel that is started with an impossible setup raises a configuration-error pulse and stays off.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset every register word reads 0, no beat is issued and no event pulse is raised.
- R2: Words at offsets 0x0C and 0x10 to 0x3C read back exactly what was last written. The offset is reg_addr[5:2] times four.
- R3: Writing 1 to bit 0 of the config word (0x08) enables the channel, and that bit reads 1 while the channel is active. No beat is issued until a request arrives. A request is either a write of 1 to bit 0 of the request word (0x04) or hw_req high. While a unit is pending, bit 0 of 0x04 reads 1.
- R4: Fragment-length word (0x18) bits [31:30] give the source width code, where n means 2^n bytes. Each beat counts that many bytes. The transaction ends after ceil(length/bytes) beats, where the length is 0x20 bits [27:0]. The channel then clears its own enable bit.
- R5: A 36-bit address is {high nibble, low word}. For the source, the high nibble is bits [31:28] of 0x28 and the low word is 0x10. For the destination they are bits [31:28] of 0x2C and 0x14. Each beat advances the source address by 0x24 bits [15:0] and the destination address by 0x24 bits [31:16]. The addition carries into the high nibble, and a step of 0 keeps the address fixed.
- R6: When 0x18 bit 20 (fix enable) is set, one side's address stays constant. Bit 21 picks the side: 1 holds the destination and 0 holds the source.
- R7: Bits [25:24] of 0x18 set how much one request moves: 0 for a fragment, 1 for a block, 2 or 3 for the whole transaction. After that unit the channel idles, still enabled, until the next request arrives.
- R8: frag_done, blk_done and trsc_done pulse in the cycle after the beat that reaches the corresponding length. The fragment length is 0x18 bits [16:0] and the block length is 0x1C bits [16:0]. Ending a transaction also ends its block and fragment, and ending a block also ends its fragment.
- R9: Setting bit 0 of 0x00 stops beats from the next edge. Bit 2 of 0x00 then reads 1 until the pause bit is cleared. Resuming continues with the same addresses and counts.
- R10: If the channel is enabled with a zero fragment, block or transaction length, or with a source or destination low address that is not aligned to its width, cfg_err pulses once and the channel stays disabled. The destination width code is 0x18 bits [29:28].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset within the channel bank |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| hw_req | input | 1 | Hardware transfer request |
| beat_valid | output | 1 | A beat is issued this cycle |
| beat_src | output | 36 | Source address of the beat |
| beat_dst | output | 36 | Destination address of the beat |
| frag_done | output | 1 | Fragment boundary pulse |
| blk_done | output | 1 | Block boundary pulse |
| trsc_done | output | 1 | Transaction complete pulse |
| cfg_err | output | 1 | Configuration error pulse |

## Verification
The assertions check four things on every cycle. No beat is issued while a pause is both requested and acknowledged. A transaction end always carries its block and fragment pulses and leaves the channel inactive. A held destination never moves between back-to-back beats. A configuration error never coincides with an active channel. The bench scenarios are what show the beat counts, address sequences with carry into the high nibble, and boundary-pulse totals for random widths, lengths and steps. They also cover the idle gaps between requests in fragment mode, resuming with the right address after a pause, and each kind of rejected enable.

// File: rtl/dma_seq_pkg.sv
// Shared register indices and control types for the DMA channel sequencer.
package dma_seq_pkg;
    localparam int REG_CNT = 16;

    typedef enum logic [3:0] {
        IDX_PAUSE  = 4'd0,  IDX_REQ    = 4'd1,  IDX_CFG    = 4'd2,  IDX_INTC   = 4'd3,
        IDX_SRC    = 4'd4,  IDX_DST    = 4'd5,  IDX_FRAG   = 4'd6,  IDX_BLK    = 4'd7,
        IDX_TRSC   = 4'd8,  IDX_STEP   = 4'd9,  IDX_SRC_HI = 4'd10, IDX_DST_HI = 4'd11,
        IDX_LIST   = 4'd12, IDX_FSTEP  = 4'd13, IDX_SBSTEP = 4'd14, IDX_DBSTEP = 4'd15
    } reg_idx_e;

    typedef enum logic [1:0] {
        UNIT_FRAG  = 2'd0,
        UNIT_BLOCK = 2'd1,
        UNIT_TRANS = 2'd2,
        UNIT_LIST  = 2'd3
    } unit_e;

    typedef struct packed {
        logic [1:0] src_w;
        logic [1:0] dst_w;
        unit_e      mode;
        logic       fix_en;
        logic       fix_sel;
    } chan_ctrl_t;
endpackage

// File: rtl/dma_seq_regs.sv
// Register bank of one channel: sixteen 32-bit words, field decode and
// write strobes. Assumes word-aligned offsets; live status bits are
// supplied by the sequencer and override stored bits on read.
module dma_seq_regs
    import dma_seq_pkg::*;
#(
    parameter int LO_W   = 32,
    parameter int HI_W   = 4,
    parameter int STEP_W = 16,
    parameter int FRAG_W = 17,
    parameter int BLK_W  = 17,
    parameter int TRSC_W = 28,
    localparam int AW    = LO_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              en_live,
    input  logic              armed_live,
    input  logic              pause_ack,
    output chan_ctrl_t        ctrl,
    output logic [FRAG_W-1:0] frag_len,
    output logic [BLK_W-1:0]  blk_len,
    output logic [TRSC_W-1:0] trsc_len,
    output logic [STEP_W-1:0] src_step,
    output logic [STEP_W-1:0] dst_step,
    output logic [AW-1:0]     src_base,
    output logic [AW-1:0]     dst_base,
    output logic              pause_req,
    output logic              en_set_wr,
    output logic              en_clr_wr,
    output logic              swreq_wr
);
    logic [31:0] bank [REG_CNT];
    reg_idx_e    idx;

    assign idx = reg_idx_e'(reg_addr[5:2]);

    // Store written words; everything clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_CNT; i++) bank[i] <= '0;
        end else if (reg_we) begin
            bank[idx] <= reg_wdata;
        end
    end

    // Strobes that the sequencer acts on.
    assign en_set_wr = reg_we && (idx == IDX_CFG) && reg_wdata[0];
    assign en_clr_wr = reg_we && (idx == IDX_CFG) && !reg_wdata[0];
    assign swreq_wr  = reg_we && (idx == IDX_REQ) && reg_wdata[0];

    // Read mux with live status bits merged in.
    always_comb begin
        reg_rdata = bank[idx];
        case (idx)
            IDX_PAUSE: reg_rdata[2] = pause_ack;
            IDX_REQ:   reg_rdata[0] = armed_live;
            IDX_CFG:   reg_rdata[0] = en_live;
            default:   ;
        endcase
    end

    // Field decode of the programmed words.
    always_comb begin
        ctrl.src_w   = bank[IDX_FRAG][31:30];
        ctrl.dst_w   = bank[IDX_FRAG][29:28];
        ctrl.mode    = unit_e'(bank[IDX_FRAG][25:24]);
        ctrl.fix_sel = bank[IDX_FRAG][21];
        ctrl.fix_en  = bank[IDX_FRAG][20];
        frag_len     = bank[IDX_FRAG][FRAG_W-1:0];
        blk_len      = bank[IDX_BLK][BLK_W-1:0];
        trsc_len     = bank[IDX_TRSC][TRSC_W-1:0];
        src_step     = bank[IDX_STEP][STEP_W-1:0];
        dst_step     = bank[IDX_STEP][16 +: STEP_W];
        src_base     = {bank[IDX_SRC_HI][31 -: HI_W], bank[IDX_SRC][LO_W-1:0]};
        dst_base     = {bank[IDX_DST_HI][31 -: HI_W], bank[IDX_DST][LO_W-1:0]};
        pause_req    = bank[IDX_PAUSE][0];
    end
endmodule

// File: rtl/dma_seq_len_cnt.sv
// Byte counter against one length limit. Flags the beat that reaches the
// limit; restarts from zero on that beat or when an outer unit ends.
module dma_seq_len_cnt #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         advance,
    input  logic         restart,
    input  logic [3:0]   inc,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt;
    logic [W:0]   sum;

    assign sum  = {1'b0, cnt} + (W+1)'(inc);
    assign last = sum >= {1'b0, limit};

    // Accumulate bytes per beat, wrapping to zero at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (clear)   cnt <= '0;
        else if (advance) cnt <= restart ? '0 : sum[W-1:0];
    end
endmodule

// File: rtl/dma_seq_addr.sv
// Address generator for one side: loads the 36-bit base at start and adds
// the step on each beat unless that side is held.
module dma_seq_addr #(
    parameter int AW     = 36,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [AW-1:0]     base,
    input  logic [STEP_W-1:0] step,
    input  logic              hold,
    input  logic              advance,
    output logic [AW-1:0]     addr
);
    // Running address register.
    always_ff @(posedge clk) begin
        if (!rst_n)                addr <= '0;
        else if (load)             addr <= base;
        else if (advance && !hold) addr <= addr + AW'(step);
    end
endmodule

// File: rtl/dma_chan_seq.sv
// One DMA channel sequencer: register bank, nested byte counters, two
// address generators and the request/pause control. Assumes one beat per
// cycle with no back-pressure from the data path.
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int LO_W   = 32,
    parameter int HI_W   = 4,
    parameter int STEP_W = 16,
    parameter int FRAG_W = 17,
    parameter int BLK_W  = 17,
    parameter int TRSC_W = 28,
    localparam int AW    = LO_W + HI_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [5:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          hw_req,
    output logic          beat_valid,
    output logic [AW-1:0] beat_src,
    output logic [AW-1:0] beat_dst,
    output logic          frag_done,
    output logic          blk_done,
    output logic          trsc_done,
    output logic          cfg_err
);
    chan_ctrl_t        ctrl;
    logic [FRAG_W-1:0] frag_len;
    logic [BLK_W-1:0]  blk_len;
    logic [TRSC_W-1:0] trsc_len;
    logic [STEP_W-1:0] src_step, dst_step;
    logic [AW-1:0]     src_base, dst_base;
    logic              pause_req, pause_ack, en_set_wr, en_clr_wr, swreq_wr;
    logic              active, armed;
    logic              frag_last, blk_last, trsc_last;
    logic              beat_go, unit_end, cfg_bad, start, hold_dst;
    logic [3:0]        beat_inc;
    logic [AW-1:0]     base_arr [2];
    logic [AW-1:0]     addr_arr [2];
    logic [STEP_W-1:0] step_arr [2];
    logic [1:0]        hold;

    function automatic logic [2:0] align_mask(input logic [1:0] w);
        return 3'((4'd1 << w) - 4'd1);
    endfunction

    dma_seq_regs #(
        .LO_W(LO_W), .HI_W(HI_W), .STEP_W(STEP_W),
        .FRAG_W(FRAG_W), .BLK_W(BLK_W), .TRSC_W(TRSC_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .en_live(active),
        .armed_live(armed), .pause_ack(pause_ack), .ctrl(ctrl),
        .frag_len(frag_len), .blk_len(blk_len), .trsc_len(trsc_len),
        .src_step(src_step), .dst_step(dst_step), .src_base(src_base),
        .dst_base(dst_base), .pause_req(pause_req), .en_set_wr(en_set_wr),
        .en_clr_wr(en_clr_wr), .swreq_wr(swreq_wr)
    );

    // Beat size, setup check and end-of-unit selection.
    always_comb begin
        beat_inc = 4'd1 << ctrl.src_w;
        beat_go  = active && armed && !pause_req;
        cfg_bad  = (frag_len == '0) || (blk_len == '0) || (trsc_len == '0)
                || ((src_base[2:0] & align_mask(ctrl.src_w)) != 3'd0)
                || ((dst_base[2:0] & align_mask(ctrl.dst_w)) != 3'd0);
        start    = en_set_wr && !active && !cfg_bad;
        case (ctrl.mode)
            UNIT_FRAG:  unit_end = frag_last || blk_last || trsc_last;
            UNIT_BLOCK: unit_end = blk_last || trsc_last;
            default:    unit_end = trsc_last;
        endcase
        hold[0]  = ctrl.fix_en && !ctrl.fix_sel;
        hold[1]  = ctrl.fix_en && ctrl.fix_sel;
        hold_dst = hold[1];
        base_arr[0] = src_base;
        base_arr[1] = dst_base;
        step_arr[0] = src_step;
        step_arr[1] = dst_step;
    end

    for (genvar s = 0; s < 2; s++) begin : g_side
        dma_seq_addr #(.AW(AW), .STEP_W(STEP_W)) u_addr (
            .clk(clk), .rst_n(rst_n), .load(start), .base(base_arr[s]),
            .step(step_arr[s]), .hold(hold[s]), .advance(beat_go),
            .addr(addr_arr[s])
        );
    end

    dma_seq_len_cnt #(.W(FRAG_W)) u_frag_cnt (
        .clk(clk), .rst_n(rst_n), .clear(start), .advance(beat_go),
        .restart(frag_last || blk_last || trsc_last), .inc(beat_inc),
        .limit(frag_len), .last(frag_last)
    );
    dma_seq_len_cnt #(.W(BLK_W)) u_blk_cnt (
        .clk(clk), .rst_n(rst_n), .clear(start), .advance(beat_go),
        .restart(blk_last || trsc_last), .inc(beat_inc),
        .limit(blk_len), .last(blk_last)
    );
    dma_seq_len_cnt #(.W(TRSC_W)) u_trsc_cnt (
        .clk(clk), .rst_n(rst_n), .clear(start), .advance(beat_go),
        .restart(trsc_last), .inc(beat_inc),
        .limit(trsc_len), .last(trsc_last)
    );

    // Channel state: enable, request arming, pause acknowledge, events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            armed     <= 1'b0;
            pause_ack <= 1'b0;
            frag_done <= 1'b0;
            blk_done  <= 1'b0;
            trsc_done <= 1'b0;
            cfg_err   <= 1'b0;
        end else begin
            pause_ack <= pause_req;
            frag_done <= beat_go && (frag_last || blk_last || trsc_last);
            blk_done  <= beat_go && (blk_last || trsc_last);
            trsc_done <= beat_go && trsc_last;
            cfg_err   <= en_set_wr && !active && cfg_bad;
            if (en_clr_wr) begin
                active <= 1'b0;
                armed  <= 1'b0;
            end else if (start) begin
                active <= 1'b1;
                armed  <= 1'b0;
            end else if (active) begin
                if (beat_go && trsc_last) begin
                    active <= 1'b0;
                    armed  <= 1'b0;
                end else if (beat_go && unit_end) begin
                    armed  <= 1'b0;
                end else if (!armed && (swreq_wr || hw_req)) begin
                    armed  <= 1'b1;
                end
            end
        end
    end

    assign beat_valid = beat_go;
    assign beat_src   = addr_arr[0];
    assign beat_dst   = addr_arr[1];
endmodule

// File: rtl/dma_chan_seq_chk.sv
// Property checker for the DMA channel sequencer, bound to the top module.
module dma_chan_seq_chk #(
    parameter int AW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          active,
    input logic          pause_req,
    input logic          pause_ack,
    input logic          hold_dst,
    input logic          beat_valid,
    input logic [AW-1:0] beat_dst,
    input logic          frag_done,
    input logic          blk_done,
    input logic          trsc_done,
    input logic          cfg_err
);
    // R9
    pause_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_req && pause_ack) |-> !beat_valid);

    // R8
    trsc_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trsc_done |-> (blk_done && frag_done));

    // R4
    end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trsc_done |-> !active);

    // R6
    fix_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && $past(beat_valid) && hold_dst && $past(hold_dst))
        |-> (beat_dst == $past(beat_dst)));

    // R10
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !active);
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .active(active), .pause_req(pause_req),
    .pause_ack(pause_ack), .hold_dst(hold_dst), .beat_valid(beat_valid),
    .beat_dst(beat_dst), .frag_done(frag_done), .blk_done(blk_done),
    .trsc_done(trsc_done), .cfg_err(cfg_err)
);

// File: tb/dma_chan_seq_bench.sv
// Bench for the DMA channel sequencer: directed corners plus seeded random
// transfers checked against expected values from bench functions.
module dma_chan_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB       = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hw_req = 1'b0;
    logic        beat_valid, frag_done, blk_done, trsc_done, cfg_err;
    logic [35:0] beat_src, beat_dst;

    int n_chk = 0;
    int n_fail = 0;
    int beat_cnt = 0, frag_cnt = 0, blk_cnt = 0, trsc_cnt = 0, err_cnt = 0;
    logic [35:0] src_log [MAXB];
    logic [35:0] dst_log [MAXB];

    dma_chan_seq u_dma_chan_seq (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req(hw_req),
        .beat_valid(beat_valid), .beat_src(beat_src), .beat_dst(beat_dst),
        .frag_done(frag_done), .blk_done(blk_done), .trsc_done(trsc_done),
        .cfg_err(cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: log beats and count event pulses at each falling edge.
    always @(negedge clk) begin
        if (beat_valid) begin
            if (beat_cnt < MAXB) begin
                src_log[beat_cnt] = beat_src;
                dst_log[beat_cnt] = beat_dst;
            end
            beat_cnt++;
        end
        frag_cnt += int'(frag_done);
        blk_cnt  += int'(blk_done);
        trsc_cnt += int'(trsc_done);
        err_cnt  += int'(cfg_err);
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        step();
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic clear_mon();
        beat_cnt = 0; frag_cnt = 0; blk_cnt = 0; trsc_cnt = 0; err_cnt = 0;
    endtask

    task automatic wait_idle(input int maxc);
        reg_addr = 6'h08;
        for (int i = 0; i < maxc; i++) begin
            step();
            if (reg_rdata[0] == 1'b0) break;
        end
    endtask

    task automatic prog(input logic [31:0] slo, input logic [31:0] dlo,
                        input logic [3:0] shi, input logic [3:0] dhi,
                        input int sw, input int dw, input int mode,
                        input int fe, input int fs, input int frag,
                        input int blk, input int trsc, input int sst, input int dst);
        wr(6'h10, slo);
        wr(6'h14, dlo);
        wr(6'h28, {shi, 28'h0});
        wr(6'h2C, {dhi, 28'h0});
        wr(6'h18, (32'(sw) << 30) | (32'(dw) << 28) | (32'(mode) << 24)
                | (32'(fs) << 21) | (32'(fe) << 20) | 32'(frag));
        wr(6'h1C, 32'(blk));
        wr(6'h20, 32'(trsc));
        wr(6'h24, {16'(dst), 16'(sst)});
    endtask

    function automatic void exp_units(input int trsc, input int frag, input int blk,
                                      input int bpb, output int nf, output int nb);
        int f = 0, k = 0, t = 0;
        bit tl, bl, fl;
        nf = 0; nb = 0;
        while (t < trsc) begin
            f += bpb; k += bpb; t += bpb;
            tl = (t >= trsc);
            bl = tl || (k >= blk);
            fl = bl || (f >= frag);
            if (fl) begin nf++; f = 0; end
            if (bl) begin nb++; k = 0; end
        end
    endfunction

    function automatic logic [35:0] exp_addr(input logic [35:0] base, input int stp,
                                             input bit hold, input int k);
        return hold ? base : base + 36'(k) * 36'(stp);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int bad, c, nf, nb;
        void'($urandom(32'd1234));

        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state of every word and of the outputs
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            rd(6'(i * 4), d);
            if (d != 32'h0) bad++;
        end
        check(bad == 0, "R1 registers zero after reset", bad, 0);
        repeat (4) step();
        check(beat_cnt + frag_cnt + trsc_cnt + err_cnt == 0, "R1 no activity after reset",
              beat_cnt + frag_cnt + trsc_cnt + err_cnt, 0);

        // R2: plain storage words read back
        for (int i = 3; i < 16; i++) wr(6'(i * 4), 32'hA5000000 ^ 32'(i * 32'h01010101));
        bad = 0;
        for (int i = 3; i < 16; i++) begin
            rd(6'(i * 4), d);
            if (d != (32'hA5000000 ^ 32'(i * 32'h01010101))) bad++;
        end
        check(bad == 0, "R2 register readback", bad, 0);

        // R3: enabled channel waits for a request, then runs
        prog(32'h100, 32'h200, 4'h0, 4'h0, 2, 2, 2, 0, 0, 16, 32, 32, 4, 4);
        clear_mon();
        wr(6'h08, 32'h1);
        repeat (10) step();
        check(beat_cnt == 0, "R3 no beat without request", beat_cnt, 0);
        rd(6'h08, d);
        check(d[0] == 1'b1, "R3 enable reads 1", d[0], 1);
        wr(6'h04, 32'h1);
        wait_idle(200);
        check(beat_cnt == 8, "R3 software request runs transfer", beat_cnt, 8);

        // R7: fragment mode needs one request per fragment
        prog(32'h400, 32'h800, 4'h0, 4'h0, 2, 2, 0, 0, 0, 8, 32, 32, 4, 4);
        clear_mon();
        wr(6'h08, 32'h1);
        wr(6'h04, 32'h1);
        repeat (10) step();
        check(beat_cnt == 2, "R7 one fragment per request", beat_cnt, 2);
        check(frag_cnt == 1, "R7 fragment pulse count", frag_cnt, 1);
        rd(6'h08, d);
        check(d[0] == 1'b1, "R7 channel stays enabled between units", d[0], 1);
        wr(6'h04, 32'h1);
        repeat (10) step();
        check(beat_cnt == 4, "R7 second request moves next fragment", beat_cnt, 4);
        check(src_log[2] == 36'h408, "R7 address continues", src_log[2], 36'h408);
        wr(6'h08, 32'h0);

        // R9: pause stops beats, acknowledge shows, resume continues
        prog(32'h1000, 32'h2000, 4'h0, 4'h0, 0, 0, 2, 0, 0, 16, 64, 300, 1, 1);
        clear_mon();
        hw_req = 1'b1;
        wr(6'h08, 32'h1);
        repeat (5) step();
        wr(6'h00, 32'h1);
        step();
        rd(6'h00, d);
        check(d[2] == 1'b1, "R9 pause acknowledge", d[2], 1);
        c = beat_cnt;
        repeat (10) step();
        check(beat_cnt == c && c > 0, "R9 no beats while paused", beat_cnt, c);
        wr(6'h00, 32'h0);
        wait_idle(1000);
        hw_req = 1'b0;
        check(beat_cnt == 300, "R9 all beats after resume", beat_cnt, 300);
        bad = 0;
        for (int k = 0; k < 300; k++) if (src_log[k] != 36'h1000 + 36'(k)) bad++;
        check(bad == 0, "R9 addresses continuous across pause", bad, 0);

        // R10: rejected enables
        prog(32'h0, 32'h0, 4'h0, 4'h0, 0, 0, 2, 0, 0, 4, 4, 0, 1, 1);
        clear_mon();
        wr(6'h08, 32'h1);
        step();
        check(err_cnt == 1, "R10 zero transaction length flagged", err_cnt, 1);
        rd(6'h08, d);
        check(d[0] == 1'b0, "R10 channel stays off", d[0], 0);
        prog(32'h2, 32'h0, 4'h0, 4'h0, 2, 0, 2, 0, 0, 4, 4, 4, 4, 1);
        clear_mon();
        wr(6'h08, 32'h1);
        step();
        check(err_cnt == 1, "R10 misaligned source flagged", err_cnt, 1);
        prog(32'h0, 32'h4, 4'h0, 4'h0, 0, 3, 2, 0, 0, 4, 4, 4, 1, 8);
        clear_mon();
        wr(6'h08, 32'h1);
        wr(6'h04, 32'h1);
        repeat (4) step();
        check(err_cnt == 1 && beat_cnt == 0, "R10 misaligned destination flagged", err_cnt, 1);

        // R5: carry from the low word into the high nibble
        prog(32'hFFFFFFF8, 32'h0, 4'h3, 4'h9, 3, 0, 2, 0, 0, 16, 16, 16, 8, 1);
        clear_mon();
        wr(6'h08, 32'h1);
        wr(6'h04, 32'h1);
        wait_idle(100);
        check(src_log[1] == 36'h400000000, "R5 carry into high bits", src_log[1], 36'h400000000);
        check(dst_log[1] == 36'h900000001, "R5 destination high nibble", dst_log[1], 36'h900000001);

        // R4 R5 R6 R7 R8: seeded random transfers
        for (int it = 0; it < 20; it++) begin
            int sw, dw, bpb, trsc, frag, blk, sst, dst, fe, fs, mode, nexp;
            logic [31:0] slo, dlo;
            logic [3:0] shi, dhi;
            sw = int'($urandom % 4); dw = int'($urandom % 4); bpb = 1 << sw;
            trsc = 1 + int'($urandom % 120);
            frag = 1 + int'($urandom % 40);
            blk  = 1 + int'($urandom % 80);
            sst  = int'($urandom % 20); dst = int'($urandom % 20);
            fe   = int'($urandom % 2); fs = int'($urandom % 2);
            mode = int'($urandom % 4);
            slo  = $urandom & ~32'((1 << sw) - 1);
            dlo  = $urandom & ~32'((1 << dw) - 1);
            shi  = 4'($urandom); dhi = 4'($urandom);
            prog(slo, dlo, shi, dhi, sw, dw, mode, fe, fs, frag, blk, trsc, sst, dst);
            clear_mon();
            hw_req = 1'b1;
            wr(6'h08, 32'h1);
            wait_idle(2000);
            hw_req = 1'b0;
            nexp = (trsc + bpb - 1) / bpb;
            exp_units(trsc, frag, blk, bpb, nf, nb);
            check(beat_cnt == nexp, "R4 beat count", beat_cnt, nexp);
            rd(6'h08, d);
            check(d[0] == 1'b0, "R4 enable self-clears", d[0], 0);
            check(frag_cnt == nf && trsc_cnt == 1, "R8 fragment and transaction pulses", frag_cnt, nf);
            check(blk_cnt == nb, "R8 block pulses", blk_cnt, nb);
            bad = 0;
            for (int k = 0; k < nexp && k < MAXB; k++) begin
                if (src_log[k] != exp_addr({shi, slo}, sst, fe == 1 && fs == 0, k)) bad++;
                if (dst_log[k] != exp_addr({dhi, dlo}, dst, fe == 1 && fs == 1, k)) bad++;
            end
            check(bad == 0, "R5 R6 address sequence", bad, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule